// File: doc/BRIEF.md
# Serial Scan Command Loader

This block sits between a boundary-scan user data register and a flash programmer. A host shifts a slow serial stream in, least significant bit first, on the scan data clock. Each group of 32 bits becomes one word. The first three words of a session load the programmer's start address, page count and subsector count, and each load comes with a one-cycle valid strobe. The fourth word is a trigger: it raises a one-cycle erase request and switches the loader into streaming. Every word after that is offered to the programmer's data FIFO on a valid/ready interface.

While the host shifts bits in, the bits it receives back carry the programmer's erasing flag, so the host polls the erase without a second path. On a capture marker the loader copies the flag into bit 0 of the shift register and clears the other bits, and that bit is the first one shifted out. The scan clock is far slower than the programmer's clock, so control signals cross between the two with no synchronizers. All state is reset by an asynchronous active-low scan reset.

On the FIFO side a word stays presented, unchanged, until `fifo_ready` is seen high at a clock edge. Completing a further word while one is still waiting does not overwrite it: the new word is discarded. The host is expected to pace itself so that this does not happen; the discard rule only keeps the presented data stable.

Top module: `scan_cmd_loader`

## Requirements
- R1: While `scan_rst_n` is low, and after its release before any shifting, every strobe, `erase_req`, `fifo_valid` and `scan_tdo` are 0. After a reset the next completed word loads the start address.
- R2: Bits are taken from `scan_tdi` least significant first. Bit k of a word is the value on the k-th clock edge with `scan_shift` high, counted from reset, from a capture or from the end of the previous word.
- R3: In the header phase the first word loads `start_addr`, the second loads `page_cnt` and the third loads `sect_cnt`. Each takes the low bits of the word. Its strobe is high for exactly one cycle, and the register keeps its value afterwards.
- R4: The fourth header word raises `erase_req` for exactly one cycle, with no other strobe in that cycle, and the loader moves to the streaming phase.
- R5: In the streaming phase every completed word appears on `fifo_data` with `fifo_valid` high. It is accepted on a clock edge where both `fifo_valid` and `fifo_ready` are high.
- R6: While `fifo_valid` is high and `fifo_ready` is low, `fifo_valid` stays high and `fifo_data` stays unchanged. A word completed during that time is discarded.
- R7: A clock edge with `scan_capture` high loads `erasing` into bit 0 of the shift register and 0 into the other bits. `scan_tdo` shows that bit until the next shift, and shows 0 for the following 31 shifts.
- R8: A capture clears the bit count. In the header phase it also returns the loader to the start-address slot. In the streaming phase the loader stays in streaming.
- R9: A completed word causes exactly one load, and at most one of the four header strobes is high in any cycle.
- R10: Clock edges with `scan_shift` low and `scan_capture` low change neither the bit count nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Scan data clock; clocks all state |
| scan_rst_n | input | 1 | Asynchronous active-low reset |
| scan_capture | input | 1 | Capture marker: loads status bit, realigns word |
| scan_shift | input | 1 | Shift enable for one bit per edge |
| scan_tdi | input | 1 | Serial data in, LSB first |
| scan_tdo | output | 1 | Serial data out; first bit after capture is the erasing flag |
| erasing | input | 1 | Erase-in-progress flag from the programmer |
| start_addr | output | ADDR_W | Load start address |
| start_addr_vld | output | 1 | One-cycle strobe: start address loaded |
| page_cnt | output | PAGE_W | Page count |
| page_cnt_vld | output | 1 | One-cycle strobe: page count loaded |
| sect_cnt | output | SECT_W | Subsector erase count |
| sect_cnt_vld | output | 1 | One-cycle strobe: subsector count loaded |
| erase_req | output | 1 | One-cycle erase request |
| fifo_data | output | WORD_W | Streaming data word |
| fifo_valid | output | 1 | Data word presented |
| fifo_ready | input | 1 | FIFO accepts the presented word |

## Verification
The bench builds the block with its default widths: 32-bit words and start address, a 17-bit page count and a 13-bit subsector count. An all-ones page word therefore shows that only the low bits are kept. A full 32-bit word shows the 5-bit bit counter wrapping exactly at the word boundary. With these widths, one capture-and-shift sequence covers both the header slot restart and the erasing readback, and a long idle gap with toggling serial input shows that no stray bits are taken in.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic {
    PH_HEADER = 1'b0,
    PH_STREAM = 1'b1
  } phase_e;

  typedef enum logic [1:0] {
    SLOT_ADDR  = 2'd0,
    SLOT_PAGE  = 2'd1,
    SLOT_SECT  = 2'd2,
    SLOT_ERASE = 2'd3
  } slot_e;
endpackage

// File: rtl/scl_shifter.sv
module scl_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              sdi_i,
  input  logic              status_i,
  output logic              sdo_o,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr_next;

  assign sr_next = {sdi_i, sr_q[WORD_W-1:1]};
  assign sdo_o   = sr_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (capture_i) begin
        sr_q  <= {{(WORD_W-1){1'b0}}, status_i};
        cnt_q <= '0;
      end else if (shift_i) begin
        sr_q <= sr_next;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
          word_o <= sr_next;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scl_header.sv
module scl_header
  import scl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 17,
  parameter int SECT_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              start_addr_vld_o,
  output logic [PAGE_W-1:0] page_cnt_o,
  output logic              page_cnt_vld_o,
  output logic [SECT_W-1:0] sect_cnt_o,
  output logic              sect_cnt_vld_o,
  output logic              erase_req_o,
  output logic              stream_o
);
  phase_e phase_q;
  slot_e  slot_q;

  assign stream_o = (phase_q == PH_STREAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q          <= PH_HEADER;
      slot_q           <= SLOT_ADDR;
      start_addr_o     <= '0;
      page_cnt_o       <= '0;
      sect_cnt_o       <= '0;
      start_addr_vld_o <= 1'b0;
      page_cnt_vld_o   <= 1'b0;
      sect_cnt_vld_o   <= 1'b0;
      erase_req_o      <= 1'b0;
    end else begin
      start_addr_vld_o <= 1'b0;
      page_cnt_vld_o   <= 1'b0;
      sect_cnt_vld_o   <= 1'b0;
      erase_req_o      <= 1'b0;
      if (phase_q == PH_HEADER) begin
        if (capture_i) begin
          slot_q <= SLOT_ADDR;
        end else if (done_i) begin
          unique case (slot_q)
            SLOT_ADDR: begin
              start_addr_o     <= word_i[ADDR_W-1:0];
              start_addr_vld_o <= 1'b1;
              slot_q           <= SLOT_PAGE;
            end
            SLOT_PAGE: begin
              page_cnt_o     <= word_i[PAGE_W-1:0];
              page_cnt_vld_o <= 1'b1;
              slot_q         <= SLOT_SECT;
            end
            SLOT_SECT: begin
              sect_cnt_o     <= word_i[SECT_W-1:0];
              sect_cnt_vld_o <= 1'b1;
              slot_q         <= SLOT_ERASE;
            end
            SLOT_ERASE: begin
              erase_req_o <= 1'b1;
              phase_q     <= PH_STREAM;
              slot_q      <= SLOT_ADDR;
            end
            default: slot_q <= SLOT_ADDR;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/scl_wordout.sv
module scl_wordout #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  input  logic              ready_i
);
  logic slot_free;
  assign slot_free = !valid_o || ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i && slot_free) begin
      valid_o <= 1'b1;
      data_o  <= word_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_cmd_loader.sv
module scan_cmd_loader #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 17,
  parameter int SECT_W = 13
) (
  input  logic              scan_clk,
  input  logic              scan_rst_n,
  input  logic              scan_capture,
  input  logic              scan_shift,
  input  logic              scan_tdi,
  output logic              scan_tdo,
  input  logic              erasing,
  output logic [ADDR_W-1:0] start_addr,
  output logic              start_addr_vld,
  output logic [PAGE_W-1:0] page_cnt,
  output logic              page_cnt_vld,
  output logic [SECT_W-1:0] sect_cnt,
  output logic              sect_cnt_vld,
  output logic              erase_req,
  output logic [WORD_W-1:0] fifo_data,
  output logic              fifo_valid,
  input  logic              fifo_ready
);
  logic [WORD_W-1:0] word;
  logic              done;
  logic              streaming;

  scl_shifter #(.WORD_W(WORD_W)) shifter_i (
    .clk       (scan_clk),
    .rst_n     (scan_rst_n),
    .capture_i (scan_capture),
    .shift_i   (scan_shift),
    .sdi_i     (scan_tdi),
    .status_i  (erasing),
    .sdo_o     (scan_tdo),
    .word_o    (word),
    .done_o    (done)
  );

  scl_header #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W)
  ) header_i (
    .clk              (scan_clk),
    .rst_n            (scan_rst_n),
    .capture_i        (scan_capture),
    .done_i           (done),
    .word_i           (word),
    .start_addr_o     (start_addr),
    .start_addr_vld_o (start_addr_vld),
    .page_cnt_o       (page_cnt),
    .page_cnt_vld_o   (page_cnt_vld),
    .sect_cnt_o       (sect_cnt),
    .sect_cnt_vld_o   (sect_cnt_vld),
    .erase_req_o      (erase_req),
    .stream_o         (streaming)
  );

  scl_wordout #(.WORD_W(WORD_W)) wordout_i (
    .clk     (scan_clk),
    .rst_n   (scan_rst_n),
    .load_i  (done && streaming),
    .word_i  (word),
    .valid_o (fifo_valid),
    .data_o  (fifo_data),
    .ready_i (fifo_ready)
  );
endmodule

// File: rtl/scan_cmd_loader_chk.sv
module scan_cmd_loader_chk #(
  parameter int WORD_W = 32
) (
  input logic              scan_clk,
  input logic              scan_rst_n,
  input logic              scan_capture,
  input logic              scan_tdo,
  input logic              erasing,
  input logic              start_addr_vld,
  input logic              page_cnt_vld,
  input logic              sect_cnt_vld,
  input logic              erase_req,
  input logic [WORD_W-1:0] fifo_data,
  input logic              fifo_valid,
  input logic              fifo_ready
);
  a_r9_single_header_load: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
    $countones({start_addr_vld, page_cnt_vld, sect_cnt_vld, erase_req}) <= 1);

  a_r4_erase_one_cycle: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
    erase_req |=> !erase_req);

  a_r3_addr_strobe_one_cycle: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
    start_addr_vld |=> !start_addr_vld);

  a_r6_hold_while_stalled: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
    (fifo_valid && !fifo_ready) |=> (fifo_valid && $stable(fifo_data)));

  a_r7_capture_returns_status: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
    scan_capture |=> (scan_tdo == $past(erasing)));
endmodule

bind scan_cmd_loader scan_cmd_loader_chk #(.WORD_W(WORD_W)) chk_i (
  .scan_clk       (scan_clk),
  .scan_rst_n     (scan_rst_n),
  .scan_capture   (scan_capture),
  .scan_tdo       (scan_tdo),
  .erasing        (erasing),
  .start_addr_vld (start_addr_vld),
  .page_cnt_vld   (page_cnt_vld),
  .sect_cnt_vld   (sect_cnt_vld),
  .erase_req      (erase_req),
  .fifo_data      (fifo_data),
  .fifo_valid     (fifo_valid),
  .fifo_ready     (fifo_ready)
);

// File: tb/scan_cmd_loader_tb_top.sv
module scan_cmd_loader_tb_top;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 32;
  localparam int PAGE_W = 17;
  localparam int SECT_W = 13;

  localparam int K_ADDR  = 0;
  localparam int K_PAGE  = 1;
  localparam int K_SECT  = 2;
  localparam int K_ERASE = 3;
  localparam int K_DATA  = 4;

  typedef struct {
    int          kind;
    logic [31:0] val;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic capture = 1'b0;
  logic shift = 1'b0;
  logic tdi = 1'b0;
  logic erasing = 1'b0;
  logic ready = 1'b1;
  logic tdo;
  logic [ADDR_W-1:0] start_addr;
  logic start_addr_vld;
  logic [PAGE_W-1:0] page_cnt;
  logic page_cnt_vld;
  logic [SECT_W-1:0] sect_cnt;
  logic sect_cnt_vld;
  logic erase_req;
  logic [WORD_W-1:0] fifo_data;
  logic fifo_valid;

  int n_checks = 0;
  int n_fail = 0;
  exp_t exp_q[$];
  int model_slot = 0;
  bit model_stream = 1'b0;

  always #4 clk = ~clk;

  scan_cmd_loader #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W)
  ) dut_i (
    .scan_clk(clk), .scan_rst_n(rst_n), .scan_capture(capture), .scan_shift(shift),
    .scan_tdi(tdi), .scan_tdo(tdo), .erasing(erasing),
    .start_addr(start_addr), .start_addr_vld(start_addr_vld),
    .page_cnt(page_cnt), .page_cnt_vld(page_cnt_vld),
    .sect_cnt(sect_cnt), .sect_cnt_vld(sect_cnt_vld),
    .erase_req(erase_req), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
    .fifo_ready(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // monitor: pops the scoreboard on every load the design makes
  task automatic pop_cmp(input int kind, input logic [31:0] val, input string req);
    exp_t e;
    if (exp_q.size() == 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL %s: actual unexpected load kind %0d value %h expected none", req, kind, val);
    end else begin
      e = exp_q.pop_front();
      check({req, " kind"}, 32'(kind), 32'(e.kind));
      check({req, " value"}, val, e.val);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_addr_vld) pop_cmp(K_ADDR, 32'(start_addr), "R3 addr");
      if (page_cnt_vld)   pop_cmp(K_PAGE, 32'(page_cnt), "R3 page");
      if (sect_cnt_vld)   pop_cmp(K_SECT, 32'(sect_cnt), "R3 sect");
      if (erase_req)      pop_cmp(K_ERASE, 32'd0, "R4 erase");
      if (fifo_valid && ready) pop_cmp(K_DATA, fifo_data, "R5 data");
    end
  end

  function automatic void push(input int kind, input logic [31:0] val);
    exp_t e;
    e.kind = kind;
    e.val = val;
    exp_q.push_back(e);
  endfunction

  // driver: shifts one word LSB first, returns what came out on tdo
  task automatic send_word(input logic [31:0] w, input bit dropped, output logic [31:0] out);
    if (!dropped) begin
      if (!model_stream) begin
        case (model_slot)
          0: push(K_ADDR, w);
          1: push(K_PAGE, w & ((32'd1 << PAGE_W) - 1));
          2: push(K_SECT, w & ((32'd1 << SECT_W) - 1));
          default: push(K_ERASE, 32'd0);
        endcase
        model_slot++;
        if (model_slot == 4) begin
          model_stream = 1'b1;
          model_slot = 0;
        end
      end else begin
        push(K_DATA, w);
      end
    end
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #1;
      shift = 1'b1;
      tdi = w[i];
      out[i] = tdo;
    end
    @(posedge clk); #1;
    shift = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic do_capture();
    @(posedge clk); #1;
    capture = 1'b1;
    @(posedge clk); #1;
    capture = 1'b0;
    if (!model_stream) model_slot = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] out;
    // R1 reset state
    idle(3);
    @(negedge clk);
    check("R1 strobes", {28'd0, start_addr_vld, page_cnt_vld, sect_cnt_vld, erase_req}, 32'd0);
    check("R1 fifo_valid/tdo", {30'd0, fifo_valid, tdo}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(2);

    // R7 erasing readback, R2 LSB first address load
    erasing = 1'b1;
    do_capture();
    send_word(32'h1234_5678, 1'b0, out);
    check("R7 tdo after capture, erasing=1", out, 32'h0000_0001);

    // R8 capture in header phase restarts at the address slot
    do_capture();
    send_word(32'h0026_F000, 1'b0, out);
    check("R7 tdo second capture", out, 32'h0000_0001);
    send_word(32'hFFFF_FFFF, 1'b0, out);   // R3 page truncated to 17 bits
    send_word(32'hDEAD_BEEF, 1'b0, out);   // R3 sect truncated to 13 bits
    send_word(32'h0000_0000, 1'b0, out);   // R4 erase trigger
    idle(3);
    check("R3 page held", 32'(page_cnt), 32'h0001_FFFF);
    check("R3 addr held", 32'(start_addr), 32'h0026_F000);

    // poll during streaming: R7 with erasing=0, R8 stays streaming
    erasing = 1'b0;
    do_capture();
    send_word(32'hA5A5_5A5A, 1'b0, out);
    check("R7 tdo after capture, erasing=0", out, 32'h0000_0000);

    // R10 idle with toggling tdi takes no bits
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      tdi = i[0];
    end
    tdi = 1'b0;
    send_word(32'h8000_0001, 1'b0, out);
    send_word(32'h0000_0000, 1'b0, out);
    send_word(32'hFFFF_FFFF, 1'b0, out);
    for (int i = 0; i < 4; i++) send_word(32'h1 << (i * 9), 1'b0, out);
    idle(3);

    // R6 back-pressure: hold and discard
    ready = 1'b0;
    send_word(32'hCAFE_0001, 1'b0, out);
    idle(3);
    @(negedge clk);
    check("R6 valid held", 32'(fifo_valid), 32'd1);
    check("R6 data held", fifo_data, 32'hCAFE_0001);
    send_word(32'hCAFE_0002, 1'b1, out);
    @(negedge clk);
    check("R6 data not overwritten", fifo_data, 32'hCAFE_0001);
    @(posedge clk); #1;
    ready = 1'b1;
    idle(3);
    @(negedge clk);
    check("R6 valid drops after accept", 32'(fifo_valid), 32'd0);

    // R1 reset mid-stream returns to header
    @(posedge clk); #1;
    rst_n = 1'b0;
    model_stream = 1'b0;
    model_slot = 0;
    idle(2);
    rst_n = 1'b1;
    idle(2);
    send_word(32'h0050_0000, 1'b0, out);
    idle(4);
    check("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule